// File: doc/BRIEF.md
# Processor Memory Port to Pipelined Wishbone Bridge

This block sits between a processor-style memory port (request/grant handshake with a separate read-valid response) and a pipelined Wishbone bus master. Each request the processor makes is granted in the cycle it is seen while the bridge is idle. The bridge captures the address, direction, byte lanes and write data in that cycle and turns them into exactly one single-beat pipelined Wishbone access. When the bus answers with an acknowledge or an error, the bridge returns a one-cycle completion to the core, with read data or an error flag.

The bridge keeps one busy flag. While a transaction is in flight, grant stays low and any further request waits, so at most one access is outstanding. The same module serves an instruction-fetch port or a data port. A system uses one instance per port, each with its own bus master. Arbitration between masters happens downstream.

Top module: `corebus_bridge`

## Requirements
- R1: Reset is synchronous and active high. Right after reset, wbCyc, wbStb, coreGnt and coreRvalid are low.
- R2: While no transaction is in flight (wbCyc low), coreGnt equals coreReq in the same cycle.
- R3: In the cycle after a granted request, wbCyc and wbStb are high, and wbAdr, wbWe, wbSel and wbDatO equal the coreAddr, coreWe, coreBe and coreWdata that were present at the grant.
- R4: While wbCyc is high, coreGnt is low whatever coreReq does.
- R5: wbStb stays high through every cycle in which wbStall is high. It drops after the first cycle with wbStall low, and wbCyc stays high until a response arrives.
- R6: A cycle with wbCyc high and wbAck or wbErr high ends the transaction: wbCyc and wbStb are low in the next cycle.
- R7: coreRvalid is high for exactly one cycle, the cycle after the response. On a read, coreRdata then equals the wbDatI sampled with the response.
- R8: coreErr is high together with coreRvalid when the response was wbErr, and it is low when the response was wbAck.
- R9: wbAdr, wbWe, wbSel and wbDatO hold steady from launch until the response.
- R10: wbAck or wbErr arriving while wbCyc is low is ignored: no coreRvalid follows and wbCyc stays low.
- R11: On the completion of a write, coreRdata is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| coreReq | input | 1 | Core requests an access |
| coreGnt | output | 1 | Request accepted this cycle |
| coreAddr | input | ADDR_W | Access address |
| coreWe | input | 1 | 1 = write, 0 = read |
| coreBe | input | DATA_W/8 | Byte lane enables |
| coreWdata | input | DATA_W | Write data |
| coreRvalid | output | 1 | One-cycle completion pulse |
| coreRdata | output | DATA_W | Read data (zero on writes) |
| coreErr | output | 1 | Completion carried a bus error |
| wbCyc | output | 1 | Bus cycle active |
| wbStb | output | 1 | Request strobe |
| wbAdr | output | ADDR_W | Bus address |
| wbWe | output | 1 | Bus write enable |
| wbSel | output | DATA_W/8 | Bus byte selects |
| wbDatO | output | DATA_W | Bus write data |
| wbDatI | input | DATA_W | Bus read data |
| wbAck | input | 1 | Bus acknowledge |
| wbErr | input | 1 | Bus error response |
| wbStall | input | 1 | Slave cannot take the strobe this cycle |

## Verification
Reads and writes with random address, lanes and data are run against slave behaviour that varies the number of stall cycles and the response latency. An acknowledge in the very cycle the strobe is taken separates a bridge that completes from the strobe phase from one that needs a separate wait phase. Long stalls separate a strobe that drops too early from one that is held correctly. Error responses are mixed with acknowledges so the error flag is checked for leaking across transactions. The core keeps requesting during each transaction to show that grant is held off. Stray responses sent while the bridge is idle show that it ignores them.

// File: rtl/corebus_pkg.sv
package corebus_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic launch;    // capture the core request into the bus registers
    logic complete;  // capture the bus response into the core registers
  } dpStrobe_t;

  typedef enum logic {
    ST_IDLE    = 1'b0,
    ST_ONGOING = 1'b1
  } bridgeState_t;

endpackage

// File: rtl/corebus_ctrl.sv
module corebus_ctrl
  import corebus_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      coreReq,
  input  logic      wbAck,
  input  logic      wbErr,
  input  logic      wbStall,
  output logic      coreGnt,
  output logic      busy,
  output logic      stbQ,
  output logic      rvalidQ,
  output dpStrobe_t strobe
);

  bridgeState_t state;
  logic         respSeen;

  assign busy     = (state == ST_ONGOING);
  assign respSeen = busy & (wbAck | wbErr);

  always_comb begin
    coreGnt         = coreReq & ~busy;
    strobe.launch   = coreReq & ~busy;
    strobe.complete = respSeen;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      stbQ    <= 1'b0;
      rvalidQ <= 1'b0;
    end else begin
      rvalidQ <= respSeen;
      unique case (state)
        ST_IDLE: begin
          if (coreReq) begin
            state <= ST_ONGOING;
            stbQ  <= 1'b1;
          end
        end
        ST_ONGOING: begin
          if (respSeen) begin
            state <= ST_IDLE;
            stbQ  <= 1'b0;
          end else if (stbQ && !wbStall) begin
            stbQ <= 1'b0;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/corebus_dp.sv
module corebus_dp
  import corebus_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int SEL_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  dpStrobe_t         strobe,
  input  logic [ADDR_W-1:0] coreAddr,
  input  logic              coreWe,
  input  logic [SEL_W-1:0]  coreBe,
  input  logic [DATA_W-1:0] coreWdata,
  input  logic [DATA_W-1:0] wbDatI,
  input  logic              wbErr,
  output logic [ADDR_W-1:0] adrQ,
  output logic              weQ,
  output logic [SEL_W-1:0]  selQ,
  output logic [DATA_W-1:0] datOQ,
  output logic [DATA_W-1:0] rdataQ,
  output logic              errQ
);

  always_ff @(posedge clk) begin
    if (rst) begin
      adrQ  <= '0;
      weQ   <= 1'b0;
      selQ  <= '0;
      datOQ <= '0;
    end else if (strobe.launch) begin
      adrQ  <= coreAddr;
      weQ   <= coreWe;
      selQ  <= coreBe;
      datOQ <= coreWdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdataQ <= '0;
      errQ   <= 1'b0;
    end else if (strobe.complete) begin
      rdataQ <= weQ ? '0 : wbDatI;
      errQ   <= wbErr;
    end else begin
      errQ   <= 1'b0;
    end
  end

endmodule

// File: rtl/corebus_bridge.sv
module corebus_bridge
  import corebus_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int SEL_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              coreReq,
  output logic              coreGnt,
  input  logic [ADDR_W-1:0] coreAddr,
  input  logic              coreWe,
  input  logic [SEL_W-1:0]  coreBe,
  input  logic [DATA_W-1:0] coreWdata,
  output logic              coreRvalid,
  output logic [DATA_W-1:0] coreRdata,
  output logic              coreErr,
  output logic              wbCyc,
  output logic              wbStb,
  output logic [ADDR_W-1:0] wbAdr,
  output logic              wbWe,
  output logic [SEL_W-1:0]  wbSel,
  output logic [DATA_W-1:0] wbDatO,
  input  logic [DATA_W-1:0] wbDatI,
  input  logic              wbAck,
  input  logic              wbErr,
  input  logic              wbStall
);

  dpStrobe_t strobe;
  logic      busy;
  logic      stbQ;
  logic      rvalidQ;

  corebus_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .coreReq (coreReq),
    .wbAck   (wbAck),
    .wbErr   (wbErr),
    .wbStall (wbStall),
    .coreGnt (coreGnt),
    .busy    (busy),
    .stbQ    (stbQ),
    .rvalidQ (rvalidQ),
    .strobe  (strobe)
  );

  corebus_dp #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .coreAddr  (coreAddr),
    .coreWe    (coreWe),
    .coreBe    (coreBe),
    .coreWdata (coreWdata),
    .wbDatI    (wbDatI),
    .wbErr     (wbErr),
    .adrQ      (wbAdr),
    .weQ       (wbWe),
    .selQ      (wbSel),
    .datOQ     (wbDatO),
    .rdataQ    (coreRdata),
    .errQ      (coreErr)
  );

  assign wbCyc      = busy;
  assign wbStb      = stbQ;
  assign coreRvalid = rvalidQ;

endmodule

// File: rtl/corebus_chk.sv
module corebus_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int SEL_W = DATA_W / 8
) (
  input logic              clk,
  input logic              rst,
  input logic              coreReq,
  input logic              coreGnt,
  input logic              coreRvalid,
  input logic              coreErr,
  input logic              wbCyc,
  input logic              wbStb,
  input logic [ADDR_W-1:0] wbAdr,
  input logic              wbWe,
  input logic [SEL_W-1:0]  wbSel,
  input logic [DATA_W-1:0] wbDatO,
  input logic              wbAck,
  input logic              wbErr,
  input logic              wbStall
);

  // R2
  idle_grant_chk: assert property (@(posedge clk) disable iff (rst)
    (!wbCyc && coreReq) |-> coreGnt);

  // R4
  busy_no_grant_chk: assert property (@(posedge clk) disable iff (rst)
    wbCyc |-> !coreGnt);

  // R5
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wbStb && wbStall && !wbAck && !wbErr) |=> wbStb);

  // R5
  stb_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (wbStb && !wbStall && !wbAck && !wbErr) |=> (!wbStb && wbCyc));

  // R6
  resp_end_chk: assert property (@(posedge clk) disable iff (rst)
    (wbCyc && (wbAck || wbErr)) |=> (!wbCyc && !wbStb));

  // R7
  rvalid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    coreRvalid |=> !coreRvalid);

  // R8
  err_with_valid_chk: assert property (@(posedge clk) disable iff (rst)
    coreErr |-> coreRvalid);

  // R9
  bus_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (wbCyc && !wbAck && !wbErr) |=>
      ($stable(wbAdr) && $stable(wbWe) && $stable(wbSel) && $stable(wbDatO)));

  // R10
  idle_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    !wbCyc |=> !coreRvalid);

endmodule

bind corebus_bridge corebus_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .coreReq    (coreReq),
  .coreGnt    (coreGnt),
  .coreRvalid (coreRvalid),
  .coreErr    (coreErr),
  .wbCyc      (wbCyc),
  .wbStb      (wbStb),
  .wbAdr      (wbAdr),
  .wbWe       (wbWe),
  .wbSel      (wbSel),
  .wbDatO     (wbDatO),
  .wbAck      (wbAck),
  .wbErr      (wbErr),
  .wbStall    (wbStall)
);

// File: tb/corebus_bridge_bench.sv
module corebus_bridge_bench;

  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int SEL_W  = DATA_W / 8;

  logic              clk = 1'b0;
  logic              rst;
  logic              coreReq;
  logic              coreGnt;
  logic [ADDR_W-1:0] coreAddr;
  logic              coreWe;
  logic [SEL_W-1:0]  coreBe;
  logic [DATA_W-1:0] coreWdata;
  logic              coreRvalid;
  logic [DATA_W-1:0] coreRdata;
  logic              coreErr;
  logic              wbCyc;
  logic              wbStb;
  logic [ADDR_W-1:0] wbAdr;
  logic              wbWe;
  logic [SEL_W-1:0]  wbSel;
  logic [DATA_W-1:0] wbDatO;
  logic [DATA_W-1:0] wbDatI;
  logic              wbAck;
  logic              wbErr;
  logic              wbStall;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  corebus_bridge #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_corebus_bridge (
    .clk(clk), .rst(rst),
    .coreReq(coreReq), .coreGnt(coreGnt), .coreAddr(coreAddr), .coreWe(coreWe),
    .coreBe(coreBe), .coreWdata(coreWdata), .coreRvalid(coreRvalid),
    .coreRdata(coreRdata), .coreErr(coreErr),
    .wbCyc(wbCyc), .wbStb(wbStb), .wbAdr(wbAdr), .wbWe(wbWe), .wbSel(wbSel),
    .wbDatO(wbDatO), .wbDatI(wbDatI), .wbAck(wbAck), .wbErr(wbErr), .wbStall(wbStall)
  );

  function automatic logic [DATA_W-1:0] expRdata(input logic isWrite, input logic [DATA_W-1:0] busData);
    return isWrite ? '0 : busData;
  endfunction

  task automatic check(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic runTxn(input logic [ADDR_W-1:0] a, input logic w, input logic [SEL_W-1:0] be,
                        input logic [DATA_W-1:0] wd, input int stallCyc, input int lat,
                        input logic isErr, input logic [DATA_W-1:0] rd);
    @(negedge clk);
    coreReq = 1'b1; coreAddr = a; coreWe = w; coreBe = be; coreWdata = wd;
    #1;
    check(coreGnt == 1'b1, "R2 grant while idle", coreGnt, 1);
    @(negedge clk);
    // keep requesting with other values to test hold-off
    coreAddr = ~a; coreWdata = ~wd; coreBe = ~be; coreWe = ~w;
    #1;
    check(wbCyc && wbStb, "R3 cyc/stb after launch", {wbCyc, wbStb}, 2'b11);
    check(wbAdr == a, "R3 address", wbAdr, a);
    check(wbWe == w && wbSel == be, "R3 we/sel", {wbWe, wbSel}, {w, be});
    check(wbDatO == wd, "R3 write data", wbDatO, wd);
    check(coreGnt == 1'b0, "R4 grant held low", coreGnt, 0);
    for (int i = 0; i < stallCyc; i++) begin
      wbStall = 1'b1;
      @(negedge clk); #1;
      check(wbStb == 1'b1, "R5 stb held under stall", wbStb, 1);
      check(coreGnt == 1'b0, "R4 grant held low", coreGnt, 0);
    end
    wbStall = 1'b0;
    if (lat > 0) begin
      @(negedge clk); #1;
      check(wbStb == 1'b0 && wbCyc == 1'b1, "R5 stb drop, cyc held", {wbStb, wbCyc}, 2'b01);
      for (int i = 1; i < lat; i++) begin
        @(negedge clk); #1;
        check(wbCyc == 1'b1 && wbStb == 1'b0, "R5 waiting for response", {wbCyc, wbStb}, 2'b10);
        check(wbAdr == a && wbDatO == wd && wbSel == be, "R9 bus fields stable",
              {wbAdr, wbDatO}, {a, wd});
        check(coreGnt == 1'b0 && coreRvalid == 1'b0, "R4 no grant/valid mid-transaction",
              {coreGnt, coreRvalid}, 0);
      end
    end
    coreReq = 1'b0;
    wbAck = ~isErr; wbErr = isErr; wbDatI = rd;
    @(negedge clk);
    wbAck = 1'b0; wbErr = 1'b0; wbDatI = $urandom;
    #1;
    check(wbCyc == 1'b0 && wbStb == 1'b0, "R6 transaction ended", {wbCyc, wbStb}, 0);
    check(coreRvalid == 1'b1, "R7 rvalid after response", coreRvalid, 1);
    if (w) check(coreRdata == expRdata(w, rd), "R11 write rdata zero", coreRdata, expRdata(w, rd));
    else   check(coreRdata == expRdata(w, rd), "R7 read data", coreRdata, expRdata(w, rd));
    check(coreErr == isErr, "R8 error flag", coreErr, isErr);
    @(negedge clk); #1;
    check(coreRvalid == 1'b0 && coreErr == 1'b0, "R7 rvalid one cycle", {coreRvalid, coreErr}, 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=<100000", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; coreReq = 0; coreAddr = 0; coreWe = 0; coreBe = 0; coreWdata = 0;
    wbDatI = 0; wbAck = 0; wbErr = 0; wbStall = 0;
    repeat (3) @(negedge clk);
    #1;
    check({wbCyc, wbStb, coreGnt, coreRvalid} == 4'b0010 || {wbCyc, wbStb, coreRvalid} == 3'b000,
          "R1 reset state", {wbCyc, wbStb, coreRvalid}, 0);
    rst = 1'b0;
    @(negedge clk); #1;
    check({wbCyc, wbStb, coreGnt, coreRvalid} == 4'b0000, "R1 idle after reset",
          {wbCyc, wbStb, coreGnt, coreRvalid}, 0);

    // directed corners
    runTxn(32'h0000_0080, 1'b0, 4'hF, 32'h0, 0, 0, 1'b0, 32'hDEAD_BEEF); // ack same cycle as strobe
    runTxn(32'h1000_0004, 1'b1, 4'h3, 32'hCAFE_F00D, 5, 3, 1'b0, 32'h1234_5678); // write, stall
    runTxn(32'h2000_0008, 1'b0, 4'h1, 32'h0, 2, 1, 1'b1, 32'h5555_AAAA); // read error
    runTxn(32'h3000_000C, 1'b1, 4'h8, 32'h0BAD_CAFE, 0, 0, 1'b1, 32'h0); // write error

    // R10: stray responses while idle
    @(negedge clk);
    wbAck = 1'b1; wbDatI = 32'hFFFF_FFFF;
    @(negedge clk);
    wbAck = 1'b0; wbErr = 1'b1;
    #1;
    check(coreRvalid == 1'b0 && wbCyc == 1'b0, "R10 stray ack ignored", {coreRvalid, wbCyc}, 0);
    @(negedge clk);
    wbErr = 1'b0;
    #1;
    check(coreRvalid == 1'b0 && coreErr == 1'b0 && wbCyc == 1'b0, "R10 stray err ignored",
          {coreRvalid, coreErr, wbCyc}, 0);

    // random traffic
    for (int n = 0; n < 60; n++) begin
      runTxn($urandom, 1'($urandom), SEL_W'($urandom), $urandom,
             int'($urandom % 4), int'($urandom % 4), 1'(($urandom % 5) == 0), $urandom);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule